// File: doc/BRIEF.md
# Event Counter Unit with Latency Drain

This block is a memory-mapped performance monitor with four 48-bit event counters. Each counter is bound by software to an 8-bit event code. One family of codes counts single-cycle occurrence pulses from a vector of event inputs. A second family accumulates latency: every clock, the counter adds the current outstanding-request count of one selected source.

Counting is gated by a global enable bit and by one enable bit per counter. Before software reads latency results it stops counting and then starts a drain. While the drain bit is set, enabled latency counters keep adding in-flight request time. Hardware drops the bit by itself once every latency source reports zero outstanding requests. Software polls that bit and reads the counters once it is 0.

A counter that wraps past its maximum value sets a sticky status bit. A maskable interrupt output reports those status bits, and software clears them with a write-one-to-clear register. A read-only register returns a fixed identifier.

Top module: `evt_pmu_top`

## Requirements
- R1: After synchronous active-low reset, all counters, select codes, counter enables, the global enable, status and the drain bit read 0. The mask register reads 4'hF (all masked), and `irq` is 0.
- R2: With the global enable (bit 6 of 0x408) and the counter's enable set, codes 0x00 to 0x0E add 1 per cycle in which `evt_pulse[code]` is high.
- R3: Under the same enables, codes 0x80 to 0x87 add `lat_count[code-0x80]` every cycle. Source k occupies bits [6k+5:6k] of `lat_count`.
- R4: Bit i of 0x1C00 enables counter i. When this bit is clear, or the global enable is clear (and no drain applies), the counter holds its value.
- R5: The select register at 0x1D00 holds the code of counter i in bits [8i+7:8i]. A write replaces all four codes, and a read returns them packed the same way.
- R6: Any code outside 0x00..0x0E and 0x80..0x87 makes the counter count nothing.
- R7: A write to 0x1E00+8i loads counter i with `reg_wdata[47:0]`; this takes precedence over counting in that cycle. A read of that address returns the count with bits 63:48 zero.
- R8: When an add carries a counter past 2^48-1, the counter keeps the low 48 bits of the sum and sets status bit i, readable at 0x808.
- R9: Writing a value with bit i set to 0x80C clears status bit i, unless the same counter wraps in that cycle. Status bits with 0 in the written value are unchanged.
- R10: Bit i of 0x800 masks counter i. `irq` is 1 exactly when some status bit is set while its mask bit is 0.
- R11: Writing 1 to bit 0 of 0x400 sets the drain bit. Writing 0 there has no effect. While the drain bit is set, enabled latency-code counters keep adding even with the global enable clear; occurrence-code counters do not. The bit reads 0 on the cycle after one in which every latency source is 0 and no new drain write occurs.
- R12: Address 0x1C04 reads the fixed identifier 32'h0001_0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Register byte address |
| reg_wen | input | 1 | Write strobe for the current address |
| reg_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| reg_rdata | output | 64 | Read data for the current address (combinational) |
| evt_pulse | input | 15 | Occurrence pulses, one per occurrence code |
| lat_count | input | 48 | Eight 6-bit outstanding-request counts |
| irq | output | 1 | Overflow interrupt request |

## Verification
On every cycle, the assertions check the following:
- a counter with no add and no load holds its value;
- a counter that crosses its maximum wraps to a small value and sets its status bit;
- a status bit survives every cycle that carries no clear for it;
- the drain bit follows its set, hold and self-clear rules against the live outstanding counts.

Only the bench's scenarios can show the following:
- each code drives the intended input;
- unused codes count nothing;
- loads win over counting;
- the mask gates the interrupt;
- latency counters, and not occurrence counters, keep adding after the global stop.

The bench checks these against a reference model running under mixed random traffic.

// File: rtl/pmu_pkg.sv
// Package: register map and code ranges shared by the counter unit.
// Assumes a 16-bit byte address bus; offsets are fixed by software.
package pmu_pkg;
    localparam logic [15:0] A_DRAIN   = 16'h0400;
    localparam logic [15:0] A_CTRL    = 16'h0408;
    localparam logic [15:0] A_MASK    = 16'h0800;
    localparam logic [15:0] A_STAT    = 16'h0808;
    localparam logic [15:0] A_CLR     = 16'h080C;
    localparam logic [15:0] A_EN      = 16'h1C00;
    localparam logic [15:0] A_VER     = 16'h1C04;
    localparam logic [15:0] A_SEL     = 16'h1D00;
    localparam logic [15:0] A_CNT     = 16'h1E00;
    localparam int          GLOB_BIT  = 6;
    localparam logic [7:0]  LAT_BASE  = 8'h80;
endpackage

// File: rtl/pmu_inc_sel.sv
// Module: decodes one counter's event code into an add value.
// Occurrence codes pick one pulse bit; latency codes pick one
// outstanding count; every other code yields zero.
module pmu_inc_sel #(
    parameter int NUM_OCC = 15,
    parameter int NUM_LAT = 8,
    parameter int OUT_W   = 6
) (
    input  logic [7:0]               code,
    input  logic [NUM_OCC-1:0]       evt_pulse,
    input  logic [NUM_LAT*OUT_W-1:0] lat_count,
    output logic [OUT_W-1:0]         inc,
    output logic                     is_lat
);
    import pmu_pkg::*;

    // Match the code against both families and select the source.
    always_comb begin
        inc    = '0;
        is_lat = 1'b0;
        for (int k = 0; k < NUM_OCC; k++) begin
            if (code == 8'(k))
                inc = {{(OUT_W-1){1'b0}}, evt_pulse[k]};
        end
        for (int k = 0; k < NUM_LAT; k++) begin
            if (code == LAT_BASE + 8'(k)) begin
                inc    = lat_count[k*OUT_W +: OUT_W];
                is_lat = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmu_counter.sv
// Module: one wide event counter with load and wrap detection.
// Assumes load and add never need to combine; load wins.
module pmu_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [INC_W-1:0] inc,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0] sum;

    // Widened sum exposes the carry out of the counter.
    always_comb sum = {1'b0, cnt} + {{(CNT_W+1-INC_W){1'b0}}, inc};

    assign wrap = add_en && !ld && sum[CNT_W];

    // Counter register: load, add, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (ld)     cnt <= ld_val;
        else if (add_en) cnt <= sum[CNT_W-1:0];
    end

    // R4: no add and no load means the value holds.
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !ld) |=> $stable(cnt));

    // R8: crossing the maximum lands below the added amount.
    assert_wrap_to_small_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !ld && cnt == CNT_MAX && inc != '0) |=>
        (cnt < {{(CNT_W-INC_W){1'b0}}, $past(inc)}));

    // R7: a load takes effect on the next cycle.
    assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/pmu_drain.sv
// Module: self-clearing drain bit for latency accounting.
// Set by software, dropped after a cycle in which every
// latency source reports zero outstanding requests.
module pmu_drain #(
    parameter int NUM_LAT = 8,
    parameter int OUT_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic [NUM_LAT*OUT_W-1:0] lat_count,
    output logic                     draining
);
    logic idle;

    // All sources retired when the packed count vector is zero.
    always_comb idle = (lat_count == '0);

    // Drain state: a new request wins over the self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 draining <= 1'b0;
        else if (req)               draining <= 1'b1;
        else if (draining && idle)  draining <= 1'b0;
    end

    assert_drain_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> draining);

    assert_drain_holds_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && lat_count != '0) |=> draining);

    assert_drain_selfclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && lat_count == '0 && !req) |=> !draining);
endmodule

// File: rtl/evt_pmu_top.sv
// Module: memory-mapped event counter unit with latency drain.
// Holds control, mask, status, select and enable registers, and
// instantiates one selector and one counter per channel. Read data
// is combinational from the address; writes land on the clock edge.
module evt_pmu_top #(
    parameter int          NUM_CNT = 4,
    parameter int          CNT_W   = 48,
    parameter int          NUM_OCC = 15,
    parameter int          NUM_LAT = 8,
    parameter int          OUT_W   = 6,
    parameter logic [31:0] VERSION = 32'h0001_0100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              reg_addr,
    input  logic                     reg_wen,
    input  logic [63:0]              reg_wdata,
    output logic [63:0]              reg_rdata,
    input  logic [NUM_OCC-1:0]       evt_pulse,
    input  logic [NUM_LAT*OUT_W-1:0] lat_count,
    output logic                     irq
);
    import pmu_pkg::*;

    localparam int SEL_PER_REG = 4;

    logic               glob_en;
    logic [NUM_CNT-1:0] cnt_en;
    logic [NUM_CNT-1:0] irq_mask;
    logic [NUM_CNT-1:0] status;
    logic [7:0]         sel_code [NUM_CNT];
    logic [NUM_CNT-1:0] is_lat;
    logic [NUM_CNT-1:0] add_en;
    logic [NUM_CNT-1:0] ld;
    logic [NUM_CNT-1:0] wrap;
    logic [CNT_W-1:0]   cnt [NUM_CNT];
    logic [OUT_W-1:0]   inc [NUM_CNT];
    logic               draining;
    logic               drain_req;
    logic               clr_wr;

    assign drain_req = reg_wen && reg_addr == A_DRAIN && reg_wdata[0];
    assign clr_wr    = reg_wen && reg_addr == A_CLR;

    // Global and per-counter enable, mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en  <= 1'b0;
            cnt_en   <= '0;
            irq_mask <= '1;
        end else if (reg_wen) begin
            if (reg_addr == A_CTRL) glob_en  <= reg_wdata[GLOB_BIT];
            if (reg_addr == A_EN)   cnt_en   <= reg_wdata[NUM_CNT-1:0];
            if (reg_addr == A_MASK) irq_mask <= reg_wdata[NUM_CNT-1:0];
        end
    end

    pmu_drain #(.NUM_LAT(NUM_LAT), .OUT_W(OUT_W)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (drain_req),
        .lat_count (lat_count),
        .draining  (draining)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_ch
        localparam logic [15:0] SEL_ADDR = 16'(int'(A_SEL) + (i / SEL_PER_REG) * 4);
        localparam logic [15:0] CNT_ADDR = 16'(int'(A_CNT) + i * 8);
        localparam int          SEL_LSB  = (i % SEL_PER_REG) * 8;

        // Event code byte for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                              sel_code[i] <= '0;
            else if (reg_wen && reg_addr == SEL_ADDR) sel_code[i] <= reg_wdata[SEL_LSB +: 8];
        end

        pmu_inc_sel #(.NUM_OCC(NUM_OCC), .NUM_LAT(NUM_LAT), .OUT_W(OUT_W)) u_sel (
            .code      (sel_code[i]),
            .evt_pulse (evt_pulse),
            .lat_count (lat_count),
            .inc       (inc[i]),
            .is_lat    (is_lat[i])
        );

        assign ld[i]     = reg_wen && reg_addr == CNT_ADDR;
        assign add_en[i] = cnt_en[i] && (glob_en || (draining && is_lat[i]));

        pmu_counter #(.CNT_W(CNT_W), .INC_W(OUT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .add_en (add_en[i]),
            .inc    (inc[i]),
            .ld     (ld[i]),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .cnt    (cnt[i]),
            .wrap   (wrap[i])
        );

        // Sticky overflow status; a wrap beats a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)                         status[i] <= 1'b0;
            else if (wrap[i])                   status[i] <= 1'b1;
            else if (clr_wr && reg_wdata[i])    status[i] <= 1'b0;
        end

        assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(clr_wr && reg_wdata[i])) |=> status[i]);

        assert_wrap_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> status[i]);
    end

    // Interrupt: any unmasked status bit.
    assign irq = |(status & ~irq_mask);

    // Read multiplexer driven by the address alone.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DRAIN: reg_rdata[0]           = draining;
            A_CTRL:  reg_rdata[GLOB_BIT]    = glob_en;
            A_MASK:  reg_rdata[NUM_CNT-1:0] = irq_mask;
            A_STAT:  reg_rdata[NUM_CNT-1:0] = status;
            A_EN:    reg_rdata[NUM_CNT-1:0] = cnt_en;
            A_VER:   reg_rdata[31:0]        = VERSION;
            default: reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == 16'(int'(A_SEL) + (i / SEL_PER_REG) * 4))
                reg_rdata[(i % SEL_PER_REG) * 8 +: 8] = sel_code[i];
            if (reg_addr == 16'(int'(A_CNT) + i * 8))
                reg_rdata = {{(64-CNT_W){1'b0}}, cnt[i]};
        end
    end

    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

// File: tb/tb_evt_pmu_top.sv
module tb_evt_pmu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [14:0] evt_pulse = '0;
    logic [47:0] lat_count = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    // Reference model state
    logic [47:0] m_cnt [4];
    logic [7:0]  m_sel [4];
    logic [3:0]  m_en, m_mask, m_stat;
    logic        m_glob, m_drain;

    evt_pmu_top dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .lat_count(lat_count), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [5:0] ref_inc(input logic [7:0] code, output logic lat);
        lat = 1'b0;
        if (code <= 8'h0E) return {5'b0, evt_pulse[code[3:0]]};
        if (code >= 8'h80 && code <= 8'h87) begin
            lat = 1'b1;
            return lat_count[6*code[2:0] +: 6];
        end
        return 6'd0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
        m_en = '0; m_mask = 4'hF; m_stat = '0; m_glob = 1'b0; m_drain = 1'b0;
    endtask

    // Advance the model by one clock using the inputs now applied.
    task automatic model_step();
        logic [47:0] nc [4];
        logic [3:0]  ns;
        logic        idle;
        idle = (lat_count == '0);
        ns = m_stat;
        for (int i = 0; i < 4; i++) begin
            logic lat; logic [5:0] inc; logic [48:0] s; logic act;
            inc = ref_inc(m_sel[i], lat);
            act = m_en[i] && (m_glob || (m_drain && lat));
            nc[i] = m_cnt[i];
            if (reg_wen && reg_addr == 16'h1E00 + 16'(i*8)) nc[i] = reg_wdata[47:0];
            else if (act) begin
                s = {1'b0, m_cnt[i]} + 49'(inc);
                nc[i] = s[47:0];
                if (s[48]) ns[i] = 1'b1;
            end
            if (!(act && !(reg_wen && reg_addr == 16'h1E00 + 16'(i*8)) &&
                  ({1'b0, m_cnt[i]} + 49'(inc)) >> 48 != 0))
                if (reg_wen && reg_addr == 16'h080C && reg_wdata[i]) ns[i] = 1'b0;
        end
        if (reg_wen) begin
            if (reg_addr == 16'h0408) m_glob = reg_wdata[6];
            if (reg_addr == 16'h1C00) m_en   = reg_wdata[3:0];
            if (reg_addr == 16'h0800) m_mask = reg_wdata[3:0];
            if (reg_addr == 16'h1D00)
                for (int i = 0; i < 4; i++) m_sel[i] = reg_wdata[8*i +: 8];
        end
        if (reg_wen && reg_addr == 16'h0400 && reg_wdata[0]) m_drain = 1'b1;
        else if (m_drain && idle) m_drain = 1'b0;
        for (int i = 0; i < 4; i++) m_cnt[i] = nc[i];
        m_stat = ns;
    endtask

    task automatic tick(input logic wr, input logic [15:0] a, input logic [63:0] d);
        reg_wen = wr; reg_addr = a; reg_wdata = d;
        model_step();
        @(posedge clk);
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        tick(1'b1, a, d);
    endtask

    task automatic chk(input string tag, input logic [15:0] a, input logic [63:0] exp);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input string tag);
        logic e;
        e = |(m_stat & ~m_mask);
        #1;
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < 4; i++) chk(tag, 16'h1E00 + 16'(i*8), {16'b0, m_cnt[i]});
        chk(tag, 16'h0808, {60'b0, m_stat});
        chk(tag, 16'h0400, {63'b0, m_drain});
        chk_irq(tag);
    endtask

    function automatic logic [7:0] rand_code();
        int r;
        r = $urandom_range(0, 9);
        if (r < 4) return 8'($urandom_range(0, 14));
        if (r < 8) return 8'h80 + 8'($urandom_range(0, 7));
        return (r == 8) ? 8'h3C : 8'hFF;
    endfunction

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_all("R1");
        chk("R1", 16'h0800, 64'hF);
        chk("R1", 16'h1D00, 64'h0);
        chk("R1", 16'h0408, 64'h0);
        // R12 identifier
        chk("R12", 16'h1C04, 64'h0001_0100);

        // R5 select register packing
        wr(16'h1D00, 64'h8203_3C01);
        chk("R5", 16'h1D00, 64'h8203_3C01);

        // R6 unused code counts nothing while everything else is busy
        wr(16'h1C00, 64'hF);
        wr(16'h0408, 64'h40);
        evt_pulse = '1;
        for (int k = 0; k < 8; k++) lat_count[6*k +: 6] = 6'd5;
        repeat (10) tick(1'b0, 16'h0, 64'h0);
        chk("R6", 16'h1E08, 64'h0);
        chk_all("R2 R3");

        // R4 per-counter disable holds value
        wr(16'h1C00, 64'hE);
        repeat (5) tick(1'b0, 16'h0, 64'h0);
        chk_all("R4");

        // R8 R10 R9 wrap, interrupt, clear
        wr(16'h1E00, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R7", 16'h1E00, 64'h0000_FFFF_FFFF_FFFE);
        wr(16'h1C00, 64'hF);
        evt_pulse = 15'h0002;
        repeat (3) tick(1'b0, 16'h0, 64'h0);
        chk("R8", 16'h0808, {60'b0, m_stat});
        chk("R8", 16'h1E00, 64'h1);
        chk_irq("R10 masked");
        wr(16'h0800, 64'h0);
        chk_irq("R10 unmasked");
        wr(16'h080C, 64'h2);
        chk_all("R9");
        wr(16'h080C, 64'hF);
        chk_irq("R9 R10");

        // R11 drain: latency keeps adding after stop, occurrence does not
        wr(16'h1D00, 64'h8200_0082);
        wr(16'h1E00, 64'h0);
        evt_pulse = '1;
        lat_count = '0;
        lat_count[12 +: 6] = 6'd3;
        repeat (4) tick(1'b0, 16'h0, 64'h0);
        wr(16'h0408, 64'h0);
        wr(16'h0400, 64'h0);
        chk("R11 write0", 16'h0400, 64'h0);
        wr(16'h0400, 64'h1);
        repeat (4) tick(1'b0, 16'h0, 64'h0);
        chk("R11 busy", 16'h0400, 64'h1);
        chk_all("R11 accumulate");
        lat_count = '0;
        tick(1'b0, 16'h0, 64'h0);
        chk("R11 selfclear", 16'h0400, 64'h0);
        chk_all("R11 after");

        // Random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            evt_pulse = 15'($urandom);
            for (int k = 0; k < 8; k++)
                lat_count[6*k +: 6] = ($urandom_range(0, 3) == 0) ? 6'd0 : 6'($urandom);
            if ($urandom_range(0, 19) == 0) begin
                int r;
                r = $urandom_range(0, 7);
                case (r)
                    0: wr(16'h0408, {57'b0, 1'($urandom), 6'b0});
                    1: wr(16'h1C00, 64'($urandom_range(0, 15)));
                    2: wr(16'h0800, 64'($urandom_range(0, 15)));
                    3: wr(16'h080C, 64'($urandom_range(0, 15)));
                    4: wr(16'h0400, 64'h1);
                    5: wr(16'h1D00, {32'b0, rand_code(), rand_code(), rand_code(), rand_code()});
                    6: wr(16'h1E00 + 16'($urandom_range(0, 3) * 8),
                          {16'hFFFF, 32'hFFFF_FFFF, 16'($urandom_range(16'hFF00, 16'hFFFF))});
                    default: wr(16'h0400, 64'h0);
                endcase
            end else begin
                tick(1'b0, 16'h0, 64'h0);
            end
            if (c % 100 == 99) chk_all("R2 R3 R8 R11 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule